// File: doc/BRIEF.md
# Serial ADC Power-Mode Controller

This block sits on the device side of a serial-interfaced sampling converter. It watches an active-low chip select, a serial clock and a serial data line, all of them asynchronous to the system clock. From each 16-clock frame it captures an 8-bit control word. The two mode bits of that word decide what governs power-down: the chip-select level, the end of each conversion, or nothing at all.

The block tracks three power conditions: shutdown, standby and powered. It also marks the waking interval between a low-power state and full readiness. That interval is a count of system clocks, and its length depends on which low-power state the wake started from. For each frame the block gives one strobe at the sampling instant and one pulse at the end of conversion. A second flag marks any sample taken before the circuitry was ready. The converter core and the analog front end use these outputs to gate their own work.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset the control word is all zeros, so mode is 00 and the block is in shutdown with ready low.
- R2: Data-in is shifted in MSB first on the first 8 rising serial-clock edges of a frame. Mode is bits 1:0 of that byte and takes effect after the 8th rising edge. A frame that ends before its 8th rising edge leaves the mode unchanged.
- R3: In mode 00, a low chip select powers the block up from shutdown. A high chip select sends it to shutdown at once, even in the middle of a frame.
- R4: In mode 01 the block stays powered whatever the chip select does.
- R5: In mode 10, the 16th rising serial-clock edge of a frame sends the block to shutdown. The first falling serial-clock edge after chip select falls starts power-up.
- R6: In mode 11 the block behaves as in R5, except that it enters standby instead of shutdown.
- R7: Ready rises only after a wake interval. The interval is WAKE_OFF_CYC system clocks when waking from shutdown and WAKE_STBY_CYC when waking from standby. Ready is never high in shutdown or standby.
- R8: Each frame gives exactly one sample strobe, on its 2nd rising serial-clock edge. It gives one end-of-conversion pulse on its 16th rising edge, and none if chip select rises earlier.
- R9: A sample taken while ready is low gives one sample_bad pulse. A sample taken while ready is high gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, idles high |
| din | input | 1 | Serial data in |
| mode | output | 2 | Current power mode from the control word |
| pwr_off | output | 1 | Block is in shutdown |
| pwr_stby | output | 1 | Block is in standby |
| pwr_on | output | 1 | Block is powered or waking |
| ready | output | 1 | Wake interval finished, fully powered |
| sample_stb | output | 1 | One-cycle pulse at the sampling edge |
| sample_bad | output | 1 | One-cycle pulse: the last sample came before ready |
| eoc | output | 1 | One-cycle pulse at end of conversion |

## Verification
A wrong edge count shows up within one frame. The sample strobe or the end-of-conversion pulse goes missing or is duplicated, and in the automatic modes pwr_off or pwr_stby is not raised after the 16th edge. A control word latched from the wrong bits or on the wrong edge appears on the mode port as soon as chip select rises. A wrong wake-delay choice shows either as ready rising too early or late against the expected count, or as sample_bad disagreeing with a sample placed before or after the wake interval ends.

// File: rtl/adc_pwr_pkg.sv
// Shared types for the serial ADC power-mode controller.
// Assumes: mode encoding is fixed by the control-word bit positions.
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        MODE_CS   = 2'b00,   // chip select governs power
        MODE_ON   = 2'b01,   // always powered
        MODE_AOFF = 2'b10,   // shutdown after each conversion
        MODE_ASTB = 2'b11    // standby after each conversion
    } pmode_t;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_STBY = 2'd1,
        PS_WAKE = 2'd2,
        PS_ON   = 2'd3
    } pstate_t;

endpackage

// File: rtl/adc_pwr_sync.sv
// Multi-stage synchroniser with edge detection for a bundle of asynchronous
// single-bit inputs. Assumes input pulses are wider than STAGES+1 clocks.
module adc_pwr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    input  logic [WIDTH-1:0] reset_val,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] chain [STAGES+1];

    assign chain[0] = async_in;

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            // one synchroniser flop per stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= reset_val;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    logic [WIDTH-1:0] prev;

    // previous synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= reset_val;
        else        prev <= chain[STAGES];
    end

    assign level = chain[STAGES];
    assign rise  = chain[STAGES] & ~prev;
    assign fall  = ~chain[STAGES] & prev;

endmodule

// File: rtl/adc_pwr_frame.sv
// Frame tracker: counts serial-clock edges from the chip-select fall,
// captures the control byte, and raises the sample, end-of-conversion and
// first-falling-edge pulses. Assumes synchronised, edge-detected inputs.
module adc_pwr_frame #(
    parameter int FRAME_LEN   = 16,
    parameter int CTRL_BITS   = 8,
    parameter int SAMPLE_EDGE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_low,
    input  logic                 cs_fall,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 din_s,
    output logic [CTRL_BITS-1:0] ctrl,
    output logic                 sample_p,
    output logic                 eoc_p,
    output logic                 ffall_p
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CTRL_IDX = CNT_W'(CTRL_BITS - 1);
    localparam logic [CNT_W-1:0] SMP_IDX  = CNT_W'(SAMPLE_EDGE - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_LEN);

    logic [CNT_W-1:0]     cnt;
    logic [CTRL_BITS-2:0] shreg;
    logic                 fall_seen;

    // edge counting, byte capture and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            ctrl      <= '0;
            fall_seen <= 1'b0;
            sample_p  <= 1'b0;
            eoc_p     <= 1'b0;
            ffall_p   <= 1'b0;
        end else begin
            sample_p <= 1'b0;
            eoc_p    <= 1'b0;
            ffall_p  <= 1'b0;
            if (cs_fall) begin
                cnt       <= '0;
                fall_seen <= 1'b0;
            end else if (cs_low) begin
                if (sclk_fall && !fall_seen) begin
                    fall_seen <= 1'b1;
                    ffall_p   <= 1'b1;
                end
                if (sclk_rise && cnt != FULL) begin
                    cnt <= cnt + 1'b1;
                    if (cnt < CTRL_IDX)  shreg <= {shreg[CTRL_BITS-3:0], din_s};
                    if (cnt == CTRL_IDX) ctrl  <= {shreg, din_s};
                    if (cnt == SMP_IDX)  sample_p <= 1'b1;
                    if (cnt == LAST_IDX) eoc_p    <= 1'b1;
                end
            end
        end
    end

    p_single_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sample_p |=> !sample_p);

    p_ctrl_frozen_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> $stable(ctrl));

    p_eoc_not_with_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eoc_p && sample_p));

endmodule

// File: rtl/adc_pwr_fsm.sv
// Power-state machine with wake timer. Applies the mode rules to the
// chip-select level and frame events and raises ready after the wake delay.
// Assumes single-cycle event pulses from the frame tracker.
module adc_pwr_fsm
    import adc_pwr_pkg::*;
#(
    parameter int WAKE_OFF_CYC  = 625,
    parameter int WAKE_STBY_CYC = 125
) (
    input  logic   clk,
    input  logic   rst_n,
    input  pmode_t mode,
    input  logic   cs_low,
    input  logic   eoc_i,
    input  logic   ffall_i,
    input  logic   sample_i,
    output logic   pwr_off,
    output logic   pwr_stby,
    output logic   pwr_on,
    output logic   ready,
    output logic   sample_bad
);
    localparam int MAX_CYC = (WAKE_OFF_CYC > WAKE_STBY_CYC) ? WAKE_OFF_CYC : WAKE_STBY_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] LOAD_OFF  = TMR_W'(WAKE_OFF_CYC - 1);
    localparam logic [TMR_W-1:0] LOAD_STBY = TMR_W'(WAKE_STBY_CYC - 1);

    pstate_t          st;
    logic [TMR_W-1:0] tmr;
    logic             low_pwr;

    assign low_pwr = (st == PS_OFF) || (st == PS_STBY);

    // next power state and wake timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PS_OFF;
            tmr <= '0;
        end else begin
            if (st == PS_WAKE) begin
                if (tmr == '0) st <= PS_ON;
                else           tmr <= tmr - 1'b1;
            end
            unique case (mode)
                MODE_CS: begin
                    if (!cs_low) begin
                        st <= PS_OFF;
                    end else if (low_pwr) begin
                        st  <= PS_WAKE;
                        tmr <= (st == PS_STBY) ? LOAD_STBY : LOAD_OFF;
                    end
                end
                MODE_ON: begin
                    if (low_pwr) begin
                        st  <= PS_WAKE;
                        tmr <= (st == PS_STBY) ? LOAD_STBY : LOAD_OFF;
                    end
                end
                default: begin
                    if (eoc_i) begin
                        st <= (mode == MODE_ASTB) ? PS_STBY : PS_OFF;
                    end else if (ffall_i && low_pwr) begin
                        st  <= PS_WAKE;
                        tmr <= (st == PS_STBY) ? LOAD_STBY : LOAD_OFF;
                    end
                end
            endcase
        end
    end

    // flag samples taken before the wake interval ends
    always_ff @(posedge clk) begin
        if (!rst_n) sample_bad <= 1'b0;
        else        sample_bad <= sample_i && (st != PS_ON);
    end

    assign pwr_off  = (st == PS_OFF);
    assign pwr_stby = (st == PS_STBY);
    assign pwr_on   = (st == PS_WAKE) || (st == PS_ON);
    assign ready    = (st == PS_ON);

    p_cs_high_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CS && !cs_low) |=> pwr_off);

    p_always_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ON && ready) |=> ready);

    p_eoc_shutdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AOFF && eoc_i) |=> pwr_off);

    p_eoc_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ASTB && eoc_i) |=> pwr_stby);

    p_ready_after_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(st) == PS_WAKE);

    p_no_bad_when_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && ready) |=> !sample_bad);

endmodule

// File: rtl/adc_pwr_ctrl.sv
// Top of the serial ADC power-mode controller: synchronises the serial
// pins, tracks frames and the control byte, and runs the power FSM.
// Assumes sclk idles high and is much slower than clk.
module adc_pwr_ctrl
    import adc_pwr_pkg::*;
#(
    parameter int FRAME_LEN     = 16,
    parameter int CTRL_BITS     = 8,
    parameter int SAMPLE_EDGE   = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int WAKE_OFF_CYC  = 625,
    parameter int WAKE_STBY_CYC = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       din,
    output logic [1:0] mode,
    output logic       pwr_off,
    output logic       pwr_stby,
    output logic       pwr_on,
    output logic       ready,
    output logic       sample_stb,
    output logic       sample_bad,
    output logic       eoc
);
    localparam int NSIG = 3;

    logic [NSIG-1:0]      lvl, rise, fall;
    logic [CTRL_BITS-1:0] ctrl;
    logic                 ffall;

    adc_pwr_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  ({din, sclk, cs_n}),
        .reset_val (3'b011),
        .level     (lvl),
        .rise      (rise),
        .fall      (fall)
    );

    adc_pwr_frame #(
        .FRAME_LEN   (FRAME_LEN),
        .CTRL_BITS   (CTRL_BITS),
        .SAMPLE_EDGE (SAMPLE_EDGE)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (~lvl[0]),
        .cs_fall   (fall[0]),
        .sclk_rise (rise[1]),
        .sclk_fall (fall[1]),
        .din_s     (lvl[2]),
        .ctrl      (ctrl),
        .sample_p  (sample_stb),
        .eoc_p     (eoc),
        .ffall_p   (ffall)
    );

    assign mode = ctrl[1:0];

    adc_pwr_fsm #(
        .WAKE_OFF_CYC  (WAKE_OFF_CYC),
        .WAKE_STBY_CYC (WAKE_STBY_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (pmode_t'(ctrl[1:0])),
        .cs_low     (~lvl[0]),
        .eoc_i      (eoc),
        .ffall_i    (ffall),
        .sample_i   (sample_stb),
        .pwr_off    (pwr_off),
        .pwr_stby   (pwr_stby),
        .pwr_on     (pwr_on),
        .ready      (ready),
        .sample_bad (sample_bad)
    );

endmodule

// File: tb/tb_adc_pwr_ctrl.sv
module tb_adc_pwr_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
    logic [1:0] mode;
    logic pwr_off, pwr_stby, pwr_on, ready, sample_stb, sample_bad, eoc;

    int checks = 0, errors = 0;
    int n_stb = 0, n_eoc = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    adc_pwr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .mode(mode), .pwr_off(pwr_off), .pwr_stby(pwr_stby), .pwr_on(pwr_on),
        .ready(ready), .sample_stb(sample_stb), .sample_bad(sample_bad), .eoc(eoc)
    );

    // pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (sample_stb) n_stb++;
        if (eoc)        n_eoc++;
        if (sample_bad) n_bad++;
    end

    typedef struct packed {
        logic [7:0]  w;
        logic [15:0] gap;
        logic [1:0]  mode;
        logic        off;
        logic        stby;
        logic        bad;
    } vec_t;

    // frame byte, gap after first falling edge, expected mode/off/stby/bad
    localparam vec_t VEC [10] = '{
        '{8'h01, 16'd700, 2'd1, 1'b0, 1'b0, 1'b0},  // R3 wake, R2 write 01
        '{8'h01, 16'd0,   2'd1, 1'b0, 1'b0, 1'b0},  // R4 stays on
        '{8'h03, 16'd0,   2'd3, 1'b0, 1'b1, 1'b0},  // R6 standby at end
        '{8'h03, 16'd200, 2'd3, 1'b0, 1'b1, 1'b0},  // R7 short wake done
        '{8'h03, 16'd0,   2'd3, 1'b0, 1'b1, 1'b1},  // R9 sample too early
        '{8'h02, 16'd0,   2'd2, 1'b1, 1'b0, 1'b1},  // R5 shutdown at end
        '{8'h02, 16'd200, 2'd2, 1'b1, 1'b0, 1'b1},  // R7 long wake not done
        '{8'h02, 16'd700, 2'd2, 1'b1, 1'b0, 1'b0},  // R7 long wake done
        '{8'h00, 16'd0,   2'd0, 1'b1, 1'b0, 1'b1},  // R5 wake on fall, R3 off
        '{8'h00, 16'd700, 2'd0, 1'b1, 1'b0, 1'b0}   // R3 mode 00 frame
    };

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive a frame of nclk clocks, byte w first (MSB first), gap after first fall
    task automatic run_frame(input logic [7:0] w, input int gap, input int nclk, input bit raise_cs);
        cs_n = 1'b0;
        waitc(8);
        for (int i = 0; i < nclk; i++) begin
            sclk = 1'b0;
            din  = (i < 8) ? w[7-i] : 1'b0;
            waitc(8 + ((i == 0) ? gap : 0));
            sclk = 1'b1;
            waitc(8);
        end
        if (raise_cs) begin
            cs_n = 1'b1;
            waitc(20);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, e0, b0;
        waitc(3);
        rst_n = 1'b1;
        waitc(3);
        // R1 reset state
        chk("R1 mode", mode, 0);
        chk("R1 pwr_off", pwr_off, 1);
        chk("R1 ready", ready, 0);
        chk("R1 pwr_stby", pwr_stby, 0);

        foreach (VEC[k]) begin
            s0 = n_stb; e0 = n_eoc; b0 = n_bad;
            run_frame(VEC[k].w, int'(VEC[k].gap), 16, 1'b1);
            chk("R2 mode after frame", mode, VEC[k].mode);
            chk("R3 R4 R5 R6 pwr_off", pwr_off, VEC[k].off);
            chk("R3 R4 R5 R6 pwr_stby", pwr_stby, VEC[k].stby);
            chk("R8 sample strobes", n_stb - s0, 1);
            chk("R8 eoc pulses", n_eoc - e0, 1);
            chk("R9 sample_bad pulses", n_bad - b0, VEC[k].bad);
        end

        // R7 long wake boundary in mode 00 (block is off, mode 00)
        cs_n = 1'b0;
        waitc(600);
        chk("R7 ready before long wake", ready, 0);
        chk("R3 powering with cs low", pwr_on, 1);
        waitc(60);
        chk("R7 ready after long wake", ready, 1);
        cs_n = 1'b1;
        waitc(10);

        // R3 chip select rises mid-frame: shutdown at once, no eoc
        s0 = n_stb; e0 = n_eoc;
        cs_n = 1'b0;
        waitc(700);
        run_frame(8'h00, 0, 5, 1'b0);
        cs_n = 1'b1;
        waitc(6);
        chk("R3 off after mid-frame cs rise", pwr_off, 1);
        chk("R3 ready dropped", ready, 0);
        chk("R8 no eoc on aborted frame", n_eoc - e0, 0);
        chk("R8 sample on aborted frame", n_stb - s0, 1);

        // R2 frame ending before the 8th edge leaves mode unchanged
        run_frame(8'hFF, 0, 7, 1'b1);
        chk("R2 short frame mode", mode, 0);
        chk("R2 short frame state", pwr_off, 1);

        // R4 mode 01 ignores chip select
        run_frame(8'h01, 700, 16, 1'b1);
        waitc(700);
        chk("R4 on with cs high", pwr_on, 1);
        chk("R4 ready with cs high", ready, 1);
        chk("R4 mode", mode, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule